// File: doc/BRIEF.md
# Camera Video Output Formatter

This block is the last stage of a camera video pipeline. It drives the pixel output bus and the pixel clock that leaves the chip. It takes two kinds of input data. The first is a raw converter sample. The second is post-processed luma and chroma. It also takes horizontal sync, vertical sync and an active-video flag. From these it produces the Y and C output buses, delayed copies of the sync and active signals, and an output pixel clock.

The block runs from a clock at twice the pixel rate. An input `pixCe` is high on every other cycle. Each cycle where `pixCe` is high is a "step edge": the block takes a new input pixel there and launches the previous pixel onto its outputs. The output clock is a plain register output, so it has no combinational glitches.

One control byte configures the block. Software writes and reads it through a small register port. The byte selects:
- the data source,
- whether the output clock runs all the time or only during active video,
- which edge of the output clock launches the data,
- a 16-bit or an 8-bit output format,
- the master-crystal frequency, which is used to flag operating modes that need the faster crystal.

Top module: `cam_out_formatter`

## Requirements
- R1: After reset the control byte reads 0x01. Y, C, the sync and active outputs and the output clock are all 0.
- R2: The control byte sits at address 0x22. It reads back exactly as written, including bits 4 to 6. A write to any other address changes nothing, and a read of any other address returns 0. The read data follows the address in the same cycle.
- R3: A pixel taken at one step edge appears on Y, C, hsync, vsync and active together at the next step edge. Between step edges the outputs do not change. This timing is the same in every mode.
- R4: The source is set by control bit 3. When it is 1, Y carries the processed luma and C the processed chroma. When it is 0, Y carries the raw sample and C is 0x80 (16-bit mode, bit 7 = 0).
- R5: Control bit 7 = 1 selects 8-bit mode. C is then held at 0x80 and Y alternates two bytes within the active window. The first active pixel of each line gives the first byte. The first byte is the sample when bit 3 = 0 and the luma when bit 3 = 1. The second byte is 0x80 when bit 3 = 0 and the chroma when bit 3 = 1. Outside the active window Y carries the first-byte value.
- R6: When control bit 1 = 0 the output clock is continuous. After each step edge it is the inverse of polarity bit 2. After each other edge it equals bit 2.
- R7: When control bit 1 = 1 and the pixel being launched is inactive, the output clock stays at the level of bit 2 for the whole pixel. Only whole pulses appear when gating starts or stops.
- R8: Control bit 2 = 0 makes the data change on the rising edge of the output clock. Bit 2 = 1 makes it change on the falling edge.
- R9: Bits 4 to 6 of the control byte have no effect on any output.
- R10: `modeFault` is 1 exactly when `opMode` is 4 or 5 and control bit 0 (the crystal select: 0 = 24 MHz, 1 = 27 MHz) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| pixCe | input | 1 | Pixel step, high on alternate cycles |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| opMode | input | 3 | Current operating mode code |
| modeFault | output | 1 | Mode needs the 27 MHz crystal but bit 0 is 0 |
| rawSample | input | 8 | Raw converter sample |
| procY | input | 8 | Processed luma |
| procC | input | 8 | Processed chroma |
| hsIn | input | 1 | Horizontal sync in |
| vsIn | input | 1 | Vertical sync in |
| actIn | input | 1 | Active video in |
| yOut | output | 8 | Y output bus |
| cOut | output | 8 | C output bus |
| hsOut | output | 1 | Delayed horizontal sync |
| vsOut | output | 1 | Delayed vertical sync |
| actOut | output | 1 | Delayed active video |
| pixClkOut | output | 1 | Output pixel clock |

## Verification
Each data, sync and active result is due at the step edge that follows the step edge where its pixel was taken. That is two clock cycles later. The formatting uses the control byte as it stood before that launching edge. The output clock level is due after every edge, and its expected value comes from the polarity and gating bits and the active flag of the launched pixel. The bench's reference model advances only on rising edges. It compares every output on the falling edge that follows, so a result is never read in the cycle it is written. Register read data is checked 1 ns after the address is set, and `modeFault` is checked 1 ns after `opMode` changes.

// File: rtl/cof_pkg.sv
package cof_pkg;
  // Control byte bit positions (software-visible layout).
  localparam int BIT_XTAL   = 0;
  localparam int BIT_GATE   = 1;
  localparam int BIT_POL    = 2;
  localparam int BIT_SRC    = 3;
  localparam int BIT_NARROW = 7;

  // Strobes from control to datapath.
  typedef struct packed {
    logic step;     // pixel step edge
    logic useProc;  // processed source
    logic narrow;   // 8-bit output
    logic gate;     // clock gated to active video
    logic pol;      // 1 = falling launch edge
  } strobe_t;
endpackage

// File: rtl/cof_ctrl.sv
module cof_ctrl
  import cof_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int REG_W        = 8,
  parameter int MODE_W       = 3,
  parameter int CTRL_ADDR    = 'h22,
  parameter int CTRL_RESET   = 'h01,
  parameter int FAST_MODE_LO = 4,
  parameter int FAST_MODE_HI = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixCe,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [MODE_W-1:0] opMode,
  output logic              modeFault,
  output logic [REG_W-1:0]  ctrlByte,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] ADDR_HIT = ADDR_W'(CTRL_ADDR);
  localparam logic [REG_W-1:0]  RST_VAL  = REG_W'(CTRL_RESET);

  logic [REG_W-1:0] ctrlQ;
  logic             fastMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= RST_VAL;
    end else if (regWrEn && (regAddr == ADDR_HIT)) begin
      ctrlQ <= regWrData;
    end
  end

  always_comb begin
    fastMode  = (opMode == MODE_W'(FAST_MODE_LO)) || (opMode == MODE_W'(FAST_MODE_HI));
    modeFault = fastMode && !ctrlQ[BIT_XTAL];
  end

  always_comb begin
    strb.step    = pixCe;
    strb.useProc = ctrlQ[BIT_SRC];
    strb.narrow  = ctrlQ[BIT_NARROW];
    strb.gate    = ctrlQ[BIT_GATE];
    strb.pol     = ctrlQ[BIT_POL];
  end

  assign ctrlByte = ctrlQ;
endmodule

// File: rtl/cof_datapath.sv
module cof_datapath
  import cof_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] rawSample,
  input  logic [DATA_W-1:0] procY,
  input  logic [DATA_W-1:0] procC,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic              actIn,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cOut,
  output logic              hsOut,
  output logic              vsOut,
  output logic              actOut,
  output logic              pixClkOut
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam int                SYNC_W   = 3;

  // Capture stage.
  logic [DATA_W-1:0] aRaw, aY, aC;
  logic [SYNC_W-1:0] aSync;   // {hs, vs, act}
  logic              aAct;

  always_ff @(posedge clk) begin
    if (rst) begin
      aRaw  <= '0;
      aY    <= '0;
      aC    <= '0;
      aSync <= '0;
    end else if (strb.step) begin
      aRaw  <= rawSample;
      aY    <= procY;
      aC    <= procC;
      aSync <= {hsIn, vsIn, actIn};
    end
  end
  assign aAct = aSync[0];

  // Byte-phase tracking for 8-bit output.
  logic lastAct, bytePhase, firstAct, secondByte;
  logic [DATA_W-1:0] wideY, wideC, nextY, nextC, altByte;

  always_comb begin
    firstAct   = aAct && !lastAct;
    secondByte = aAct && !firstAct && bytePhase;
    wideY      = strb.useProc ? aY : aRaw;
    wideC      = strb.useProc ? aC : MID_CODE;
    altByte    = strb.useProc ? aC : MID_CODE;
    if (strb.narrow) begin
      nextY = secondByte ? altByte : wideY;
      nextC = MID_CODE;
    end else begin
      nextY = wideY;
      nextC = wideC;
    end
  end

  // Launch stage: data, sync and clock leave on the same edge.
  logic [SYNC_W-1:0] outSync;
  logic              clkQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      yOut      <= '0;
      cOut      <= '0;
      outSync   <= '0;
      lastAct   <= 1'b0;
      bytePhase <= 1'b0;
    end else if (strb.step) begin
      yOut      <= nextY;
      cOut      <= nextC;
      outSync   <= aSync;
      lastAct   <= aAct;
      bytePhase <= aAct && !secondByte;
    end
  end

  // Output clock: whole periods only, decided at the step edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      clkQ <= 1'b0;
    end else if (strb.step) begin
      clkQ <= (strb.gate && !aAct) ? strb.pol : !strb.pol;
    end else begin
      clkQ <= strb.pol;
    end
  end

  assign hsOut     = outSync[2];
  assign vsOut     = outSync[1];
  assign actOut    = outSync[0];
  assign pixClkOut = clkQ;
endmodule

// File: rtl/cam_out_formatter.sv
module cam_out_formatter
  import cof_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int MODE_W    = 3,
  parameter int CTRL_ADDR = 'h22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixCe,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [MODE_W-1:0] opMode,
  output logic              modeFault,
  input  logic [DATA_W-1:0] rawSample,
  input  logic [DATA_W-1:0] procY,
  input  logic [DATA_W-1:0] procC,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic              actIn,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] cOut,
  output logic              hsOut,
  output logic              vsOut,
  output logic              actOut,
  output logic              pixClkOut
);
  strobe_t    strb;
  logic [7:0] ctrlByte;

  cof_ctrl #(
    .ADDR_W(ADDR_W), .REG_W(8), .MODE_W(MODE_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .pixCe(pixCe), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .opMode(opMode), .modeFault(modeFault),
    .ctrlByte(ctrlByte), .strb(strb)
  );

  assign regRdData = (regAddr == ADDR_W'(CTRL_ADDR)) ? ctrlByte : 8'h00;

  cof_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .rawSample(rawSample), .procY(procY),
    .procC(procC), .hsIn(hsIn), .vsIn(vsIn), .actIn(actIn), .yOut(yOut),
    .cOut(cOut), .hsOut(hsOut), .vsOut(vsOut), .actOut(actOut),
    .pixClkOut(pixClkOut)
  );
endmodule

// File: rtl/cof_checker.sv
module cof_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pixCe,
  input logic [7:0]        ctrlByte,
  input logic [DATA_W-1:0] yOut,
  input logic [DATA_W-1:0] cOut,
  input logic              hsOut,
  input logic              actOut,
  input logic              pixClkOut
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  // R3: outputs only move at step edges
  p_hold_between_r3: assert property (@(posedge clk) disable iff (rst)
    !pixCe |=> ($stable(yOut) && $stable(cOut) && $stable(hsOut) && $stable(actOut)));

  // R6: clock sits at polarity level after non-step edges
  p_mid_level_r6: assert property (@(posedge clk) disable iff (rst)
    !pixCe |=> (pixClkOut == $past(ctrlByte[2])));

  // R7: gated clock idles for an inactive pixel
  p_gate_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (pixCe && ctrlByte[1]) |=> (actOut || (pixClkOut == $past(ctrlByte[2]))));

  // R8: launch edge has the selected direction when ungated
  p_launch_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (pixCe && !ctrlByte[1]) |=> (pixClkOut != $past(ctrlByte[2])));

  // R4: raw source forces mid-scale chroma
  p_raw_chroma_r4: assert property (@(posedge clk) disable iff (rst)
    (pixCe && !ctrlByte[3]) |=> (cOut == MID_CODE));

  // R5: 8-bit mode holds C at mid-scale
  p_narrow_chroma_r5: assert property (@(posedge clk) disable iff (rst)
    (pixCe && ctrlByte[7]) |=> (cOut == MID_CODE));
endmodule

bind cam_out_formatter cof_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .pixCe(pixCe), .ctrlByte(ctrlByte), .yOut(yOut),
  .cOut(cOut), .hsOut(hsOut), .actOut(actOut), .pixClkOut(pixClkOut)
);

// File: tb/cam_out_formatter_bench.sv
module cam_out_formatter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixCe = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h22;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [2:0] opMode = 3'd0;
  logic modeFault;
  logic [7:0] rawSample = 8'h00, procY = 8'h00, procC = 8'h00;
  logic hsIn = 1'b0, vsIn = 1'b0, actIn = 1'b0;
  logic [7:0] yOut, cOut;
  logic hsOut, vsOut, actOut, pixClkOut;

  int total = 0;
  int bad = 0;
  bit checkOn = 1'b0;
  bit tagR9 = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cam_out_formatter u_cam_out_formatter (
    .clk(clk), .rst(rst), .pixCe(pixCe), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .opMode(opMode),
    .modeFault(modeFault), .rawSample(rawSample), .procY(procY), .procC(procC),
    .hsIn(hsIn), .vsIn(vsIn), .actIn(actIn), .yOut(yOut), .cOut(cOut),
    .hsOut(hsOut), .vsOut(vsOut), .actOut(actOut), .pixClkOut(pixClkOut)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int actV, input int expV);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, actV, expV, $time);
    end
  endtask

  // Reference model
  logic [7:0] mCtrl;
  logic [7:0] cRaw, cY, cC;
  logic cHs, cVs, cAct, mLast, mPhase;
  logic [7:0] eY, eC;
  logic eHs, eVs, eAct, eClk;

  always @(posedge clk) begin
    if (rst) begin
      mCtrl = 8'h01; cRaw = 0; cY = 0; cC = 0; cHs = 0; cVs = 0; cAct = 0;
      mLast = 0; mPhase = 0; eY = 0; eC = 0; eHs = 0; eVs = 0; eAct = 0; eClk = 0;
    end else begin
      if (pixCe) begin
        bit second;
        bit proc;
        proc = mCtrl[3];
        second = cAct && mLast && mPhase;
        if (mCtrl[7]) begin
          eC = 8'h80;
          if (second) eY = proc ? cC : 8'h80;
          else        eY = proc ? cY : cRaw;
        end else begin
          eY = proc ? cY : cRaw;
          eC = proc ? cC : 8'h80;
        end
        if (cAct) mPhase = (!mLast) ? 1'b1 : !mPhase;
        else      mPhase = 1'b0;
        mLast = cAct;
        eHs = cHs; eVs = cVs; eAct = cAct;
        eClk = (mCtrl[1] && !cAct) ? mCtrl[2] : !mCtrl[2];
        cRaw = rawSample; cY = procY; cC = procC;
        cHs = hsIn; cVs = vsIn; cAct = actIn;
      end else begin
        eClk = mCtrl[2];
      end
      if (regWrEn && regAddr == 8'h22) mCtrl = regWrData;
    end
  end

  always @(negedge clk) begin
    if (checkOn) begin
      string tData, tClk;
      tData = tagR9 ? "R9" : (mCtrl[7] ? "R5" : "R4");
      tClk  = tagR9 ? "R9" : (mCtrl[1] ? "R7" : (mCtrl[2] ? "R8" : "R6"));
      chk(yOut == eY, tData, "yOut", yOut, eY);
      chk(cOut == eC, tData, "cOut", cOut, eC);
      chk({hsOut, vsOut, actOut} == {eHs, eVs, eAct}, "R3", "sync/act",
          {hsOut, vsOut, actOut}, {eHs, eVs, eAct});
      chk(pixClkOut == eClk, tClk, "pixClkOut", pixClkOut, eClk);
    end
  end

  int seed = 1;

  task automatic pixel(input bit hs, input bit act);
    @(negedge clk);
    pixCe = 1'b1;
    rawSample = 8'(seed * 7 + 3);
    procY = 8'(seed * 13 + 1);
    procC = 8'(seed * 5 + 200);
    hsIn = hs; actIn = act;
    seed++;
    @(negedge clk);
    pixCe = 1'b0;
  endtask

  task automatic runLine(input int actLen, input int blankLen);
    for (int i = 0; i < blankLen; i++) pixel(i < 2, 1'b0);
    for (int i = 0; i < actLen; i++) pixel(1'b0, 1'b1);
  endtask

  task automatic runLines(input int n, input int actLen);
    for (int l = 0; l < n; l++) begin
      vsIn = (l == 0);
      runLine(actLen, 4);
    end
    vsIn = 1'b0;
    runLine(0, 3);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pixCe = 1'b0; regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'h22;
  endtask

  task automatic readChk(input logic [7:0] a, input logic [7:0] expV, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdData == expV, tag, "regRdData", regRdData, expV);
    regAddr = 8'h22;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(yOut == 8'h00 && cOut == 8'h00, "R1", "data after reset", {yOut, cOut}, 0);
    chk({hsOut, vsOut, actOut, pixClkOut} == 4'b0, "R1", "ctrl outs after reset",
        {hsOut, vsOut, actOut, pixClkOut}, 0);
    readChk(8'h22, 8'h01, "R1");
    // R10: crystal bit set after reset, no fault
    opMode = 3'd4; #1;
    chk(modeFault == 1'b0, "R10", "fault mode4 27MHz", modeFault, 0);
    opMode = 3'd0;
    @(negedge clk);
    rst = 1'b0;
    checkOn = 1'b1;

    runLines(2, 6);                    // raw, 16-bit, continuous, rising
    writeReg(8'h22, 8'h09); runLines(2, 6);   // R4 processed
    writeReg(8'h22, 8'h0B); runLines(2, 5);   // R7 gated
    writeReg(8'h22, 8'h0F); runLines(2, 5);   // R7/R8 gated falling
    writeReg(8'h22, 8'h05); runLines(2, 4);   // R8 continuous falling
    writeReg(8'h22, 8'h81); runLines(3, 5);   // R5 raw 8-bit, odd length
    writeReg(8'h22, 8'h8B); runLines(3, 6);   // R5 processed 8-bit gated
    writeReg(8'h22, 8'h8D); runLines(2, 3);   // R5 processed 8-bit falling
    tagR9 = 1'b1;
    writeReg(8'h22, 8'h79); runLines(2, 5);   // R9 reserved bits set
    writeReg(8'h22, 8'hF3); runLines(2, 5);   // R9 with 8-bit gated
    tagR9 = 1'b0;

    // R2: register access
    writeReg(8'h22, 8'h71);
    readChk(8'h22, 8'h71, "R2");
    writeReg(8'h23, 8'hAA);
    readChk(8'h22, 8'h71, "R2");
    readChk(8'h23, 8'h00, "R2");
    readChk(8'h21, 8'h00, "R2");
    runLines(1, 4);

    // R10: fault decode
    writeReg(8'h22, 8'h00);
    begin
      logic [7:0] modes [4] = '{8'd4, 8'd5, 8'd3, 8'd6};
      for (int i = 0; i < 4; i++) begin
        opMode = modes[i][2:0]; #1;
        chk(modeFault == (i < 2), "R10", "fault at 24MHz", modeFault, (i < 2));
      end
    end
    writeReg(8'h22, 8'h01);
    opMode = 3'd5; #1;
    chk(modeFault == 1'b0, "R10", "fault mode5 27MHz", modeFault, 0);
    runLines(1, 3);

    checkOn = 1'b0;
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule